// File: doc/BRIEF.md
# Boot Region Isolation Guard

This block shields a program-memory region that holds immutable start-up code from everything else in program memory once that code has finished its work. Start-up firmware writes a completion flag into a small control register. When it later transfers execution to any address outside its own region, a sticky lock engages. From that point, code running elsewhere can neither fetch from, read, nor write into the start-up region. The control register and a 32-bit general status word also become read-only. The status word survives warm resets and is cleared only by a cold (power-on or brown-out) reset, so the start-up code can pass results to later boot stages.

Each request is checked on a single-cycle interface. The request carries an access kind and the region indices of the issuing code and of the addressed memory. The verdict appears in the same cycle. A blocked instruction fetch raises an instruction-bus trap. A blocked data read raises a data-bus trap. A blocked write raises no trap: it leaves an NVM error code and can raise an interrupt. A fuse input selects enforcement. With the fuse off, the registers stay writable, and only the per-region block mask restricts accesses between regions. The mask also applies with the fuse on.

The request port never applies back-pressure: `req_ready` is always high. A request is consumed in every cycle in which `req_valid` is high.

Top module: `bootlock_ctrl`

## Requirements
- R1: The status word (register address 2'd1) is 32 bits and readable and writable. It is cleared by a cold reset (`cold_rst_n` low) and keeps its value across a warm reset (`warm_rst_n` low).
- R2: The control register (address 2'd0) reads as bit0 = completion flag, bit1 = lock, bit2 = NVM interrupt enable, and zero above. Either reset clears all three bits.
- R3: With `fuse_en` high, the lock reads 1 one cycle after a valid fetch (`req_kind` 2'd0) whose target is not the start-up region while the completion flag is 1. With `fuse_en` low, the lock never sets.
- R4: The lock is sticky. Writes to bit1 of the control register have no effect, and only a reset clears the lock.
- R5: While `fuse_en` and the lock are both 1, writes to the control register and the status word are dropped, and no error flag changes.
- R6: While fused and locked, a fetch from a source outside the start-up region to a target in that region gives `req_ok` low and `trap_ibus` high in the same cycle. Error-register (address 2'd2) bit0 reads 1 from the next cycle.
- R7: While fused and locked, a data read (`req_kind` 2'd1) from a source outside the region to a target inside it gives `req_ok` low and `trap_dbus` high. Error bit1 reads 1 from the next cycle.
- R8: A blocked write (`req_kind` 2'd2) raises neither trap. It loads error bits 3:2 with code 2'd2 for a lock violation or 2'd1 for a mask violation; a lock violation takes precedence, and the latest blocked write overwrites the code. `nvm_irq` is high whenever that code is nonzero and the interrupt enable is 1.
- R9: An access whose source and target are both the start-up region is always allowed, locked or not.
- R10: An access with source index different from target index, where `region_block_mask[target]` is 1, is blocked with the same per-kind outcomes as in R6 to R8. With `fuse_en` low, accesses into the start-up region are otherwise allowed.
- R11: Error bits are cleared by writing 1 to them (bit2 or bit3 clears the code), and by either reset. A new error in the same cycle as a clear leaves the bit set. Error-register writes are not subject to the lock.
- R12: `req_ready` is always 1. Requests with `req_valid` low, or with `req_kind` 2'd3, are allowed and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low power-on / brown-out reset, clears everything |
| warm_rst_n | input | 1 | Active-low warm reset, clears all but the status word |
| fuse_en | input | 1 | Enforcement fuse |
| region_block_mask | input | NREGIONS | Per-region block bits for cross-region access |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 errors |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Always 1 |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 no access |
| req_src | input | RW | Region index of the issuing code |
| req_tgt | input | RW | Region index of the addressed memory |
| req_ok | output | 1 | Access permitted (same cycle) |
| trap_ibus | output | 1 | Instruction-bus error trap (same cycle) |
| trap_dbus | output | 1 | Data-bus error trap (same cycle) |
| nvm_irq | output | 1 | NVM error interrupt (level) |

## Verification
The hardest state to reach is the armed lock. The lock needs fuse, completion flag and an outbound fetch in that order, and then it blocks the very register writes that would let stimulus explore further. The directed part walks this sequence explicitly: it checks the dropped writes, each violation kind and the clear that loses to a new error. It then uses a warm reset to return to an unlocked state with the status word intact. The random part mixes control writes, outbound fetches, mask patterns, fuse changes and rare warm resets, so the lock arms and disarms many times under varied traffic.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_ERR  = 2'd2;

  localparam logic [1:0] NVM_CODE_NONE = 2'd0;
  localparam logic [1:0] NVM_CODE_MASK = 2'd1;
  localparam logic [1:0] NVM_CODE_SEC  = 2'd2;

  typedef struct packed {
    logic       ibus;
    logic       dbus;
    logic       nvm;
    logic [1:0] code;
  } verdict_t;

endpackage

// File: rtl/bootlock_access_chk.sv
module bootlock_access_chk
  import bootlock_pkg::*;
#(
  parameter int NREGIONS = 8,
  parameter int BOOT     = 0,
  localparam int RW      = (NREGIONS > 1) ? $clog2(NREGIONS) : 1
) (
  input  logic                valid,
  input  acc_kind_e           kind,
  input  logic [RW-1:0]       src,
  input  logic [RW-1:0]       tgt,
  input  logic [NREGIONS-1:0] mask,
  input  logic                fuse,
  input  logic                lock,
  output logic                ok,
  output verdict_t            verdict
);

  localparam logic [RW-1:0] BOOT_ID = RW'(BOOT);

  logic [NREGIONS-1:0] tgt_hot;
  logic mask_hit, guard_hit, active, blocked;

  for (genvar g = 0; g < NREGIONS; g++) begin : g_tgt
    assign tgt_hot[g] = (tgt == RW'(g));
  end

  always_comb begin
    active    = valid && (kind != ACC_NONE);
    mask_hit  = (|(tgt_hot & mask)) && (src != tgt);
    guard_hit = fuse && lock && (src != BOOT_ID) && (tgt == BOOT_ID);
    blocked   = active && (mask_hit || guard_hit);
    ok        = !blocked;
    verdict.ibus = blocked && (kind == ACC_FETCH);
    verdict.dbus = blocked && (kind == ACC_READ);
    verdict.nvm  = blocked && (kind == ACC_WRITE);
    verdict.code = !(blocked && (kind == ACC_WRITE)) ? NVM_CODE_NONE :
                   guard_hit ? NVM_CODE_SEC : NVM_CODE_MASK;
  end

endmodule

// File: rtl/bootlock_lock_seq.sv
module bootlock_lock_seq
  import bootlock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fuse,
  input  logic      done,
  input  logic      valid,
  input  acc_kind_e kind,
  input  logic      tgt_in_boot,
  output logic      lock
);

  logic arm;

  // Lock engages when execution leaves the start-up region after completion.
  assign arm = fuse && done && valid && (kind == ACC_FETCH) && !tgt_in_boot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock <= 1'b0;
    else if (arm) lock <= 1'b1;
  end

endmodule

// File: rtl/bootlock_err_flags.sv
module bootlock_err_flags
  import bootlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  verdict_t   verdict,
  input  logic       clr_en,
  input  logic [3:0] clr_bits,
  output logic [3:0] flags
);

  logic       ibus_q, dbus_q;
  logic [1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibus_q <= 1'b0;
      dbus_q <= 1'b0;
      code_q <= NVM_CODE_NONE;
    end else begin
      // A fresh error outranks a same-cycle clear.
      ibus_q <= verdict.ibus | (ibus_q & ~(clr_en & clr_bits[0]));
      dbus_q <= verdict.dbus | (dbus_q & ~(clr_en & clr_bits[1]));
      if (verdict.nvm)
        code_q <= verdict.code;
      else if (clr_en && (|clr_bits[3:2]))
        code_q <= NVM_CODE_NONE;
    end
  end

  assign flags = {code_q, dbus_q, ibus_q};

endmodule

// File: rtl/bootlock_regs.sv
module bootlock_regs
  import bootlock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wprot,
  input  logic              lock,
  input  logic [3:0]        err,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              irq_en,
  output logic [DATA_W-1:0] status
);

  logic wr_ok;
  assign wr_ok = wr_en && !wprot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      irq_en <= 1'b0;
    end else if (wr_ok && addr == ADDR_CTRL) begin
      done   <= wdata[0];
      irq_en <= wdata[2];
    end
  end

  // Status survives warm resets.
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) status <= '0;
    else if (wr_ok && addr == ADDR_STAT) status <= wdata;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTRL: rdata[2:0] = {irq_en, lock, done};
      ADDR_STAT: rdata      = status;
      ADDR_ERR:  rdata[3:0] = err;
      default:   rdata      = '0;
    endcase
  end

endmodule

// File: rtl/bootlock_ctrl.sv
module bootlock_ctrl
  import bootlock_pkg::*;
#(
  parameter int NREGIONS    = 8,
  parameter int BOOT_REGION = 0,
  parameter int DATA_W      = 32,
  localparam int RW         = (NREGIONS > 1) ? $clog2(NREGIONS) : 1
) (
  input  logic                clk,
  input  logic                cold_rst_n,
  input  logic                warm_rst_n,
  input  logic                fuse_en,
  input  logic [NREGIONS-1:0] region_block_mask,
  input  logic                reg_wr_en,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [RW-1:0]       req_src,
  input  logic [RW-1:0]       req_tgt,
  output logic                req_ok,
  output logic                trap_ibus,
  output logic                trap_dbus,
  output logic                nvm_irq
);

  localparam logic [RW-1:0] BOOT_ID = RW'(BOOT_REGION);

  logic        rst_n;
  logic        lock_q, done_q, irq_en_q, wprot;
  logic [3:0]  err_q;
  logic [DATA_W-1:0] status_q;
  acc_kind_e   kind;
  verdict_t    verdict;

  assign rst_n     = cold_rst_n & warm_rst_n;
  assign kind      = acc_kind_e'(req_kind);
  assign wprot     = fuse_en & lock_q;
  assign req_ready = 1'b1;

  bootlock_access_chk #(.NREGIONS(NREGIONS), .BOOT(BOOT_REGION)) u_chk_path (
    .valid   (req_valid),
    .kind    (kind),
    .src     (req_src),
    .tgt     (req_tgt),
    .mask    (region_block_mask),
    .fuse    (fuse_en),
    .lock    (lock_q),
    .ok      (req_ok),
    .verdict (verdict)
  );

  bootlock_lock_seq u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .fuse        (fuse_en),
    .done        (done_q),
    .valid       (req_valid),
    .kind        (kind),
    .tgt_in_boot (req_tgt == BOOT_ID),
    .lock        (lock_q)
  );

  bootlock_err_flags u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .verdict  (verdict),
    .clr_en   (reg_wr_en && reg_addr == ADDR_ERR),
    .clr_bits (reg_wdata[3:0]),
    .flags    (err_q)
  );

  bootlock_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .wprot      (wprot),
    .lock       (lock_q),
    .err        (err_q),
    .rdata      (reg_rdata),
    .done       (done_q),
    .irq_en     (irq_en_q),
    .status     (status_q)
  );

  assign trap_ibus = verdict.ibus;
  assign trap_dbus = verdict.dbus;
  assign nvm_irq   = irq_en_q && (err_q[3:2] != NVM_CODE_NONE);

endmodule

// File: rtl/bootlock_chk.sv
module bootlock_chk #(
  parameter int RW     = 3,
  parameter int BOOT   = 0,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fuse_en,
  input logic              lock,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [RW-1:0]     req_src,
  input logic [RW-1:0]     req_tgt,
  input logic              req_ok,
  input logic              trap_ibus,
  input logic              trap_dbus,
  input logic              err_ibus,
  input logic [DATA_W-1:0] status,
  input logic              reg_wr_en,
  input logic [1:0]        reg_addr
);

  localparam logic [RW-1:0] BID = RW'(BOOT);

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  assert_no_lock_unfused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fuse_en && !lock) |=> !lock);

  assert_status_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_en && lock && reg_wr_en && reg_addr == 2'd1) |=> $stable(status));

  assert_fetch_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && fuse_en && lock && req_src != BID && req_tgt == BID)
      |-> (trap_ibus && !req_ok));

  assert_ibus_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ibus |=> err_ibus);

  assert_read_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1 && fuse_en && lock && req_src != BID && req_tgt == BID)
      |-> (trap_dbus && !req_ok));

  assert_write_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2) |-> (!trap_ibus && !trap_dbus));

  assert_inside_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src == BID && req_tgt == BID) |-> req_ok);

  assert_traps_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ibus, trap_dbus}));

endmodule

bind bootlock_ctrl bootlock_chk #(.RW(RW), .BOOT(BOOT_REGION), .DATA_W(DATA_W)) u_assert (
  .clk       (clk),
  .rst_n     (rst_n),
  .fuse_en   (fuse_en),
  .lock      (lock_q),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_src   (req_src),
  .req_tgt   (req_tgt),
  .req_ok    (req_ok),
  .trap_ibus (trap_ibus),
  .trap_dbus (trap_dbus),
  .err_ibus  (err_q[0]),
  .status    (status_q),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr)
);

// File: tb/sim_bootlock_ctrl.sv
module sim_bootlock_ctrl;
  localparam int NREG = 8;
  localparam int RW   = 3;
  localparam logic [RW-1:0] B = 3'd0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic cold_rst_n, warm_rst_n, fuse_en;
  logic [NREG-1:0] mask;
  logic reg_wr_en;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic req_valid, req_ready;
  logic [1:0] req_kind;
  logic [RW-1:0] req_src, req_tgt;
  logic req_ok, trap_ibus, trap_dbus, nvm_irq;

  int checks = 0, failures = 0;
  bit m_lock, m_done, m_irqen, m_ibus, m_dbus;
  logic [1:0] m_code;
  logic [31:0] m_status;

  bootlock_ctrl #(.NREGIONS(NREG), .BOOT_REGION(0), .DATA_W(32)) u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .fuse_en(fuse_en),
    .region_block_mask(mask), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_src(req_src), .req_tgt(req_tgt),
    .req_ok(req_ok), .trap_ibus(trap_ibus), .trap_dbus(trap_dbus), .nvm_irq(nvm_irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit guard_hit(logic [RW-1:0] s, logic [RW-1:0] t);
    return fuse_en && m_lock && s != B && t == B;
  endfunction

  function automatic bit mask_hit(logic [RW-1:0] s, logic [RW-1:0] t);
    return mask[t] && s != t;
  endfunction

  task automatic readback();
    reg_addr = 2'd0; #1;
    check("R2 control readback", reg_rdata, {29'd0, m_irqen, m_lock, m_done});
    reg_addr = 2'd1; #1;
    check("R1 status readback", reg_rdata, m_status);
    reg_addr = 2'd2; #1;
    check("R11 error readback", reg_rdata, {28'd0, m_code, m_dbus, m_ibus});
    check("R8 nvm_irq level", 32'(nvm_irq), 32'((m_code != 2'd0) && m_irqen));
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bit prot;
    @(negedge clk);
    prot = fuse_en && m_lock;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (a)
      2'd0: if (!prot) begin m_done = d[0]; m_irqen = d[2]; end
      2'd1: if (!prot) m_status = d;
      2'd2: begin
        if (d[0]) m_ibus = 1'b0;
        if (d[1]) m_dbus = 1'b0;
        if (|d[3:2]) m_code = 2'd0;
      end
      default: ;
    endcase
    readback();
  endtask

  task automatic req(input logic [1:0] k, input logic [RW-1:0] s, input logic [RW-1:0] t,
                     input string tag);
    bit g, mh, blk, act, arm;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = s; req_tgt = t; reg_addr = 2'd2;
    #1;
    g   = guard_hit(s, t);
    mh  = mask_hit(s, t);
    act = (k != 2'd3);
    blk = act && (g || mh);
    arm = fuse_en && m_done && k == 2'd0 && t != B;
    check({tag, " req_ok"}, 32'(req_ok), 32'(!blk));
    check({tag, " trap_ibus"}, 32'(trap_ibus), 32'(blk && k == 2'd0));
    check({tag, " trap_dbus"}, 32'(trap_dbus), 32'(blk && k == 2'd1));
    check("R12 req_ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (blk && k == 2'd0) m_ibus = 1'b1;
    if (blk && k == 2'd1) m_dbus = 1'b1;
    if (blk && k == 2'd2) m_code = g ? 2'd2 : 2'd1;
    if (arm) m_lock = 1'b1;
    readback();
  endtask

  task automatic warm_reset();
    @(negedge clk); warm_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    warm_rst_n = 1'b1;
    m_lock = 0; m_done = 0; m_irqen = 0; m_ibus = 0; m_dbus = 0; m_code = 2'd0;
  endtask

  task automatic cold_reset();
    @(negedge clk); cold_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    cold_rst_n = 1'b1;
    m_lock = 0; m_done = 0; m_irqen = 0; m_ibus = 0; m_dbus = 0; m_code = 2'd0;
    m_status = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cold_rst_n = 0; warm_rst_n = 1; fuse_en = 0; mask = '0;
    reg_wr_en = 0; reg_addr = 2'd0; reg_wdata = '0;
    req_valid = 0; req_kind = 2'd3; req_src = '0; req_tgt = '0;
    m_lock = 0; m_done = 0; m_irqen = 0; m_ibus = 0; m_dbus = 0; m_code = 0; m_status = 0;
    repeat (3) @(negedge clk);
    cold_rst_n = 1;
    readback();                                   // R2 reset state
    check("R12 ready idle", 32'(req_ready), 32'd1);

    // R1: status persists over warm reset, cleared by cold reset
    wr(2'd1, 32'hA5A5_1234);
    wr(2'd0, 32'h5);
    warm_reset(); readback();
    check("R1 status kept over warm reset", reg_rdata, reg_rdata);
    reg_addr = 2'd1; #1; check("R1 status after warm", reg_rdata, 32'hA5A5_1234);
    cold_reset(); readback();

    // R3/R10: fuse off never locks, cross access allowed
    wr(2'd0, 32'h1);
    req(2'd0, 3'd0, 3'd4, "R3 unfused exit fetch");
    req(2'd1, 3'd5, 3'd0, "R10 unfused cross read");
    req(2'd0, 3'd5, 3'd0, "R10 unfused cross fetch");
    warm_reset();

    // R3: fused lock sequence
    fuse_en = 1;
    wr(2'd0, 32'h5);
    req(2'd0, 3'd0, 3'd0, "R9 inside fetch before exit");
    req(2'd0, 3'd0, 3'd3, "R3 exit fetch arms lock");
    reg_addr = 2'd0; #1; check("R3 lock bit set", reg_rdata, 32'h7);

    // R4/R5: protected writes dropped
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hDEAD_BEEF);
    wr(2'd0, 32'h2);

    // R6/R7/R8/R9 violations
    req(2'd0, 3'd3, 3'd0, "R6 locked cross fetch");
    req(2'd1, 3'd3, 3'd0, "R7 locked cross read");
    req(2'd2, 3'd3, 3'd0, "R8 locked cross write");
    req(2'd1, 3'd0, 3'd0, "R9 inside read after lock");
    req(2'd2, 3'd0, 3'd0, "R9 inside write after lock");
    req(2'd3, 3'd3, 3'd0, "R12 kind none");

    // R11: W1C and set wins over clear
    wr(2'd2, 32'hF);
    @(negedge clk);
    req_valid = 1; req_kind = 2'd0; req_src = 3'd6; req_tgt = 3'd0;
    reg_wr_en = 1; reg_addr = 2'd2; reg_wdata = 32'h1;
    @(negedge clk);
    req_valid = 0; reg_wr_en = 0; m_ibus = 1;
    readback();                                   // R11 set wins
    wr(2'd2, 32'h1);

    // R10: mask violation under fuse, code 1
    mask = 8'b0000_0100;
    req(2'd2, 3'd1, 3'd2, "R10 mask write");
    req(2'd1, 3'd1, 3'd2, "R10 mask read");
    req(2'd0, 3'd2, 3'd2, "R10 mask same region");
    mask = 8'b0000_0001;
    req(2'd2, 3'd4, 3'd0, "R8 guard code precedence");

    // R4: only reset clears lock
    warm_reset(); readback();
    mask = '0;

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 2) begin
        logic [1:0] a;
        a = 2'($urandom % 3);
        wr(a, (a == 2'd0) ? ($urandom & 32'h7) : $urandom);
      end else if (r == 2 && ($urandom % 10 == 0)) begin
        warm_reset(); readback();
      end else if (r == 3 && ($urandom % 6 == 0)) begin
        fuse_en = ($urandom % 4) != 0;
      end else begin
        logic [RW-1:0] s, t;
        if ($urandom % 5 == 0) mask = 8'($urandom); else if ($urandom % 3 == 0) mask = '0;
        s = ($urandom % 2) ? B : RW'($urandom);
        t = ($urandom % 2) ? B : RW'($urandom);
        req(2'($urandom % 3), s, t, "R6 R7 R8 R10 random access");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule